// File: doc/BRIEF.md
# Hash Job Command and Context Controller

This block sits between a processor's coprocessor command port and the datapath of a sponge-style hash engine. Software starts a job with two commands. The first command names the message source address and the digest destination address. The second command gives the message length and starts the job. The block holds these values as one execution context. It raises a context-valid flag that lets an external fetch engine start filling its chunk buffer.

For every chunk the fetch engine reports as full, the controller issues an absorb pulse and then a permute pulse. It then waits for the permutation core to report completion. The block counts down the remaining message bytes, so it knows which chunk is the final one. When the final permutation finishes, the controller captures the 256-bit digest. A small store machine then writes the digest to memory as four 64-bit words, and each word waits for its memory acknowledge. The job ends when the last store is acknowledged.

Top module: `hash_job_ctrl`

## Requirements
- R1: After reset, `busy`, `ctx_valid`, `absorb_go`, `perm_go` and `st_valid` are 0 and `cmd_ready` is 1.
- R2: A command accepted with `cmd_func` = 0 loads `cmd_op0` as the message address, which appears on `ctx_msg_addr` the next cycle, and loads `cmd_op1` as the digest destination address.
- R3: A command accepted with `cmd_func` = 1 loads `cmd_op0` as the length in bytes. One cycle later, `ctx_len` shows that length and both `busy` and `ctx_valid` are 1.
- R4: `cmd_ready` is 0 while `busy` is 1. A command held valid during a job has no effect until it is accepted after the job ends. A command accepted with any `cmd_func` other than 0 or 1 changes nothing.
- R5: `absorb_go` pulses for one cycle only when the controller is waiting for a chunk, `ctx_valid` is 1 and `chunk_full` is 1. While no job runs, `chunk_full` is ignored.
- R6: Each `absorb_go` pulse is followed in the next cycle by a one-cycle `perm_go` pulse. No further absorb happens until `perm_done` is seen.
- R7: A job with length L absorbs max(1, ceil(L/136)) chunks. `ctx_valid` falls in the cycle after the last absorb.
- R8: The `digest` input is captured in the cycle in which the final `perm_done` is seen. Word i (i = 0..3, ascending) is then stored with `st_addr` = destination + 8*i and `st_data` = digest bits [64*i+63:64*i]. Each store holds `st_valid`, `st_addr` and `st_data` until `st_ack`.
- R9: `busy` falls and `cmd_ready` rises in the cycle after the fourth store is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_func | input | 3 | Function select |
| cmd_op0 | input | 64 | First operand word |
| cmd_op1 | input | 64 | Second operand word |
| busy | output | 1 | Job in progress |
| ctx_valid | output | 1 | Context valid, fetch may run |
| ctx_msg_addr | output | 64 | Message source address to fetch engine |
| ctx_len | output | 64 | Message length in bytes |
| chunk_full | input | 1 | Fetch buffer holds a full chunk |
| absorb_go | output | 1 | Absorb buffer into state; frees buffer |
| perm_go | output | 1 | Start one permutation |
| perm_done | input | 1 | Permutation finished |
| digest | input | 256 | Hash state output of the permutation core |
| st_valid | output | 1 | Store request |
| st_addr | output | 64 | Store byte address |
| st_data | output | 64 | Store data word |
| st_ack | input | 1 | Store accepted |

## Verification
The collision that matters is a new command arriving at the same moment as the final store acknowledge that ends a job. The bench provokes it by raising `cmd_valid` with fresh addresses right after the start command and holding it through the whole job. Meanwhile `chunk_full` stays high during permutations. The bench checks three things: the message address never moves while `busy` is high, `busy` falls exactly one cycle after the fourth acknowledge, and the held command is taken on the following edge. Random lengths around the 136-byte chunk boundary, random permute latency and random acknowledge delay cover the chunk count, store order and digest capture.

// File: rtl/hjc_pkg.sv
// Shared constants and types for the hash job controller.
// Assumes a 136-byte absorb chunk and a 256-bit digest stored as 64-bit words.
package hjc_pkg;
    localparam int WORD_W      = 64;
    localparam int CHUNK_BYTES = 136;
    localparam int FN_ADDRS    = 0;
    localparam int FN_START    = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_ABSORB,
        SQ_PGO,
        SQ_PERM
    } seq_state_e;
endpackage

// File: rtl/hjc_cmd_ctx.sv
// Command intake and execution context.
// Takes a command when no job runs. Function 0 loads the two addresses,
// function 1 loads the length and starts a job. Other codes are dropped.
// Assumes job_end and fetch_end are single-cycle pulses.
module hjc_cmd_ctx #(
    parameter int FUNC_W = 3,
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [FUNC_W-1:0] cmd_func,
    input  logic [63:0]       cmd_op0,
    input  logic [63:0]       cmd_op1,
    input  logic              fetch_end,
    input  logic              job_end,
    output logic              cmd_ready,
    output logic              job_start,
    output logic              busy,
    output logic              ctx_valid,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic [LEN_W-1:0]  len
);
    logic accept;

    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign job_start = accept && (cmd_func == FUNC_W'(hjc_pkg::FN_START));

    // Context registers: addresses from function 0, length from function 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_addr <= '0;
            dst_addr <= '0;
            len      <= '0;
        end else if (accept && cmd_func == FUNC_W'(hjc_pkg::FN_ADDRS)) begin
            msg_addr <= cmd_op0[ADDR_W-1:0];
            dst_addr <= cmd_op1[ADDR_W-1:0];
        end else if (job_start) begin
            len <= cmd_op0[LEN_W-1:0];
        end
    end

    // Job flags: busy spans the whole job, ctx_valid only the fetch phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            ctx_valid <= 1'b0;
        end else begin
            if (job_start)      busy <= 1'b1;
            else if (job_end)   busy <= 1'b0;
            if (job_start)      ctx_valid <= 1'b1;
            else if (fetch_end) ctx_valid <= 1'b0;
        end
    end

    assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        job_start |=> (busy && ctx_valid));
    assert_ctx_within_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid |-> busy);
    assert_ctx_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy |-> $stable(msg_addr) && $stable(dst_addr) && $stable(len));
endmodule

// File: rtl/hjc_chunk_seq.sv
// Per-chunk sequencer: waits for a full buffer, pulses absorb, then permute,
// then waits for permute completion. Counts down remaining bytes to spot
// the final chunk. A zero-length message still gets one (padding) chunk.
module hjc_chunk_seq #(
    parameter int LEN_W       = 64,
    parameter int CHUNK_BYTES = hjc_pkg::CHUNK_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             job_start,
    input  logic [LEN_W-1:0] start_len,
    input  logic             chunk_full,
    input  logic             perm_done,
    output logic             absorb_go,
    output logic             perm_go,
    output logic             fetch_end,
    output logic             final_done
);
    import hjc_pkg::*;
    localparam logic [LEN_W-1:0] CHUNK = LEN_W'(CHUNK_BYTES);

    seq_state_e       state;
    logic [LEN_W-1:0] remain;
    logic             last_q;
    logic             is_last;

    assign is_last    = (remain <= CHUNK);
    assign absorb_go  = (state == SQ_ABSORB);
    assign perm_go    = (state == SQ_PGO);
    assign fetch_end  = absorb_go && is_last;
    assign final_done = (state == SQ_PERM) && perm_done && last_q;

    // Chunk state machine and remaining-byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            remain <= '0;
            last_q <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE:   if (job_start) begin
                               state  <= SQ_WAIT;
                               remain <= start_len;
                           end
                SQ_WAIT:   if (chunk_full) state <= SQ_ABSORB;
                SQ_ABSORB: begin
                               state  <= SQ_PGO;
                               last_q <= is_last;
                               if (!is_last) remain <= remain - CHUNK;
                           end
                SQ_PGO:    state <= SQ_PERM;
                SQ_PERM:   if (perm_done) state <= last_q ? SQ_IDLE : SQ_WAIT;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    assert_absorb_then_perm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        absorb_go |=> perm_go);
    assert_perm_after_absorb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        perm_go |-> $past(absorb_go));
    assert_absorb_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        absorb_go |=> !absorb_go);
endmodule

// File: rtl/hjc_digest_store.sv
// Digest write-back: captures the digest on start, then issues one 64-bit
// store per word at ascending 8-byte addresses, each held until acknowledged.
// Assumes start only arrives while idle.
module hjc_digest_store #(
    parameter int ADDR_W = 64,
    parameter int WORDS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [WORDS*64-1:0]  digest,
    input  logic [ADDR_W-1:0]    base,
    input  logic                 st_ack,
    output logic                 st_valid,
    output logic [ADDR_W-1:0]    st_addr,
    output logic [63:0]          st_data,
    output logic                 done
);
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

    logic [WORDS*64-1:0] dig_q;
    logic [ADDR_W-1:0]   base_q;
    logic [IDX_W-1:0]    idx;
    logic                active;

    assign st_valid = active;
    assign st_addr  = base_q + (ADDR_W'(idx) << 3);
    assign st_data  = dig_q[idx*64 +: 64];
    assign done     = active && st_ack && (idx == LAST_IDX);

    // Capture on start, advance one word per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            dig_q  <= '0;
            base_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            dig_q  <= digest;
            base_q <= base;
        end else if (active && st_ack) begin
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) active <= 1'b0;
        end
    end

    assert_store_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ack |=> st_valid && $stable(st_addr) && $stable(st_data));
    assert_store_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !st_valid);
endmodule

// File: rtl/hash_job_ctrl.sv
// Top of the hash job controller: command intake and context, chunk
// sequencer and digest store machine. Keccak arithmetic and the fetch
// engine sit outside and talk through chunk_full/absorb_go/perm_* and digest.
module hash_job_ctrl #(
    parameter int FUNC_W  = 3,
    parameter int ADDR_W  = 64,
    parameter int LEN_W   = 64,
    parameter int DIG_WDS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [FUNC_W-1:0]    cmd_func,
    input  logic [63:0]          cmd_op0,
    input  logic [63:0]          cmd_op1,
    output logic                 busy,
    output logic                 ctx_valid,
    output logic [ADDR_W-1:0]    ctx_msg_addr,
    output logic [LEN_W-1:0]     ctx_len,
    input  logic                 chunk_full,
    output logic                 absorb_go,
    output logic                 perm_go,
    input  logic                 perm_done,
    input  logic [DIG_WDS*64-1:0] digest,
    output logic                 st_valid,
    output logic [ADDR_W-1:0]    st_addr,
    output logic [63:0]          st_data,
    input  logic                 st_ack
);
    logic              job_start;
    logic              fetch_end;
    logic              final_done;
    logic              job_end;
    logic [ADDR_W-1:0] dst_addr;

    hjc_cmd_ctx #(.FUNC_W(FUNC_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctx (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
        .cmd_op0(cmd_op0), .cmd_op1(cmd_op1), .fetch_end(fetch_end),
        .job_end(job_end), .cmd_ready(cmd_ready), .job_start(job_start),
        .busy(busy), .ctx_valid(ctx_valid), .msg_addr(ctx_msg_addr),
        .dst_addr(dst_addr), .len(ctx_len)
    );

    hjc_chunk_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .job_start(job_start),
        .start_len(cmd_op0[LEN_W-1:0]), .chunk_full(chunk_full),
        .perm_done(perm_done), .absorb_go(absorb_go), .perm_go(perm_go),
        .fetch_end(fetch_end), .final_done(final_done)
    );

    hjc_digest_store #(.ADDR_W(ADDR_W), .WORDS(DIG_WDS)) u_st (
        .clk(clk), .rst_n(rst_n), .start(final_done), .digest(digest),
        .base(dst_addr), .st_ack(st_ack), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .done(job_end)
    );

    assert_absorb_needs_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        absorb_go |-> ctx_valid);
    assert_no_store_in_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> !ctx_valid && busy);
    assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        job_end |=> !busy && cmd_ready);
endmodule

// File: tb/sim_hash_job_ctrl.sv
module sim_hash_job_ctrl;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [2:0]   cmd_func = '0;
    logic [63:0]  cmd_op0 = '0;
    logic [63:0]  cmd_op1 = '0;
    logic         busy, ctx_valid;
    logic [63:0]  ctx_msg_addr, ctx_len;
    logic         chunk_full = 1'b0;
    logic         absorb_go, perm_go;
    logic         perm_done = 1'b0;
    logic [255:0] digest = '0;
    logic         st_valid;
    logic [63:0]  st_addr, st_data;
    logic         st_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    hash_job_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_func(cmd_func), .cmd_op0(cmd_op0), .cmd_op1(cmd_op1), .busy(busy),
        .ctx_valid(ctx_valid), .ctx_msg_addr(ctx_msg_addr), .ctx_len(ctx_len),
        .chunk_full(chunk_full), .absorb_go(absorb_go), .perm_go(perm_go),
        .perm_done(perm_done), .digest(digest), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .st_ack(st_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int exp_chunks(input logic [63:0] len);
        if (len == 0) return 1;
        return int'((len + 64'd135) / 64'd136);
    endfunction

    function automatic logic [255:0] rnd256();
        return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    endfunction

    // Single command: drive at negedge, wait for ready, drop after the edge.
    task automatic send_cmd(input logic [2:0] f, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = f; cmd_op0 = a; cmd_op1 = b;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Full job. If hold is set, a function-0 command with new addresses is
    // held valid from the start command until it is taken after the job.
    task automatic run_job(input logic [63:0] msg, input logic [63:0] dst,
                           input logic [63:0] len, input bit hold);
        int n;
        logic [255:0] dig_exp;
        logic [63:0] new_msg;
        n = exp_chunks(len);
        new_msg = {$urandom, $urandom};
        send_cmd(3'd0, msg, dst);
        chk(ctx_msg_addr == msg, "R2 msg addr", ctx_msg_addr, msg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_func = 3'd1; cmd_op0 = len; cmd_op1 = '0;
        @(negedge clk);
        if (hold) begin
            cmd_func = 3'd0; cmd_op0 = new_msg; cmd_op1 = ~dst;
        end else cmd_valid = 1'b0;
        chk(busy && ctx_valid && ctx_len == len, "R3 start", ctx_len, len);
        chk(!cmd_ready, "R4 ready low", 64'(cmd_ready), 64'd0);
        for (int c = 0; c < n; c++) begin
            chunk_full = 1'b1;
            for (int w = 0; w < 20 && !absorb_go; w++) @(negedge clk);
            chk(absorb_go, "R5 absorb", 64'(absorb_go), 64'd1);
            @(negedge clk);
            chk(perm_go && !absorb_go, "R6 perm follows", 64'(perm_go), 64'd1);
            chk(ctx_valid == (c != n-1), "R7 ctx_valid", 64'(ctx_valid), 64'(c != n-1));
            chk(ctx_msg_addr == msg, "R4 held cmd ignored", ctx_msg_addr, msg);
            for (int d = int'($urandom_range(0, 3)); d > 0; d--) begin
                @(negedge clk);
                chk(!absorb_go && !perm_go, "R6 wait perm_done", 64'(absorb_go), 64'd0);
            end
            @(negedge clk);
            chk(!absorb_go, "R6 no early absorb", 64'(absorb_go), 64'd0);
            digest = rnd256();
            dig_exp = digest;
            perm_done = 1'b1;
            chunk_full = 1'b0;
            @(negedge clk);
            perm_done = 1'b0;
            digest = rnd256();
        end
        chk(!ctx_valid && !absorb_go, "R7 no extra chunk", 64'(absorb_go), 64'd0);
        for (int i = 0; i < 4; i++) begin
            for (int w = 0; w < 20 && !st_valid; w++) @(negedge clk);
            chk(st_addr == dst + 64'(8*i), "R8 addr", st_addr, dst + 64'(8*i));
            chk(st_data == dig_exp[64*i +: 64], "R8 data", st_data, dig_exp[64*i +: 64]);
            for (int d = int'($urandom_range(0, 2)); d > 0; d--) begin
                @(negedge clk);
                chk(st_valid && st_addr == dst + 64'(8*i), "R8 hold", st_addr, dst + 64'(8*i));
            end
            chk(busy, "R9 busy until last ack", 64'(busy), 64'd1);
            st_ack = 1'b1;
            @(negedge clk);
            st_ack = 1'b0;
        end
        chk(!busy && cmd_ready && !st_valid, "R9 job end", 64'(busy), 64'd0);
        chk(ctx_msg_addr == msg, "R4 not yet taken", ctx_msg_addr, msg);
        if (hold) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(ctx_msg_addr == new_msg, "R2 held cmd taken", ctx_msg_addr, new_msg);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chunk_full = 1'b1;
        @(negedge clk);
        chk(!busy && cmd_ready && !ctx_valid && !st_valid && !absorb_go && !perm_go,
            "R1 reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!absorb_go && !ctx_valid, "R5 idle chunk_full ignored", 64'(absorb_go), 64'd0);
        chunk_full = 1'b0;
        send_cmd(3'd0, 64'h1000, 64'h2000);
        send_cmd(3'd2, 64'hdead, 64'hbeef);
        chk(!busy && ctx_msg_addr == 64'h1000, "R4 unknown func", ctx_msg_addr, 64'h1000);
        send_cmd(3'd7, 64'h0, 64'h0);
        chk(!busy && ctx_len == 0, "R4 unknown func len", ctx_len, 64'd0);
        run_job(64'h1000, 64'h8000, 64'd0, 1'b0);
        run_job(64'h2000, 64'h9000, 64'd136, 1'b1);
        run_job(64'h3000, 64'ha000, 64'd137, 1'b0);
        run_job(64'h4000, 64'hb000, 64'd272, 1'b1);
        run_job(64'h5000, 64'hc008, 64'd273, 1'b0);
        for (int j = 0; j < 6; j++)
            run_job({$urandom, $urandom}, {$urandom, 3'b000, $urandom_range(0, 536870911)},
                    64'($urandom_range(0, 1200)), j[0]);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule